// File: doc/BRIEF.md
# Byte Sum-of-Absolute-Differences Accumulator

This unit takes two source words, treats each byte in them as an unsigned 8-bit lane, and forms the absolute difference of every pair of lanes in the same position. It adds all of those differences into one scalar of the full word width. It serves a packed-SIMD execute stage on a 32-bit or 64-bit datapath, chosen by `XLEN_BYTES`. When `req_acc` is set, the previous destination value is added once to that scalar. In the instruction encoding the two forms share opcode 1111111 and funct3 000, and they differ only in the low bit of funct7: 1111110 for the plain form and 1111111 for the accumulating form. The decoder passes that bit in as `req_acc`.

The parameter `SERIAL` selects one of two engines. With `SERIAL=0` a combinational adder tree produces the result in a single registered cycle, and the unit is never busy. With `SERIAL=1` one byte pair is handled per clock. The accumulator is preloaded with zero, or with the old destination value when accumulating. In this mode `busy` blocks new requests until the result is out. Both engines produce bit-identical results. The unit does not read or write the register file.

Top module: `sad_accum_unit`

## Requirements
- R1: Byte lanes are unsigned. A lane holding 0x80 against one holding 0x7F contributes 1, and 0x00 against 0xFF contributes 255.
- R2: In the plain form (`req_acc`=0), `res_data` equals the sum of all lane absolute differences, zero-extended to XLEN bits. This is at most 255 × XLEN_BYTES.
- R3: In the accumulating form (`req_acc`=1), `dst_old` is added exactly once to the lane sum, and the total wraps modulo 2^XLEN without saturating.
- R4: With SERIAL=0, `res_valid` is high in the cycle after every cycle where `req_valid` is high, and `busy` stays low.
- R5: With SERIAL=1, an accepted request raises `busy` for exactly XLEN_BYTES cycles. `res_valid` then pulses for one cycle, XLEN_BYTES+1 cycles after acceptance, and `busy` is low in that cycle.
- R6: A request presented while `busy` is high is ignored. It changes neither the result in flight nor the number of `res_valid` pulses.
- R7: For the same request, the serial engine and the tree engine give the same `res_data`.
- R8: While `rst` is high, `res_valid`, `busy` and `res_data` are all zero.
- R9: In the plain form, the value on `dst_old` has no effect on the result.
- R10: `res_data` holds its last result in every cycle where `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe; taken when `busy` is low |
| req_acc | input | 1 | 1 selects the accumulating form (funct7 bit 0) |
| src_a | input | XLEN | First packed byte operand |
| src_b | input | XLEN | Second packed byte operand |
| dst_old | input | XLEN | Previous destination value, used only when accumulating |
| busy | output | 1 | Serial engine is working; requests are ignored |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_data | output | XLEN | Registered result, held between strobes |

## Verification
The result strobe of one request and the acceptance of the next can fall in the same cycle. In the serial engine `busy` has already dropped when `res_valid` rises, so a request driven in that cycle must be taken. The bench provokes this by driving a second request in the very cycle the first result appears. It judges the case by checking that the first value is correct in that cycle and that the second result arrives exactly XLEN_BYTES+1 cycles later with its own correct value. The other case the bench covers is a request that lands while `busy` is high. That request must be dropped without disturbing the running sum.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int LANE_W = 8;

  // width that holds 255 * nb without overflow
  function automatic int sum_width(input int nb);
    return LANE_W + ((nb > 1) ? $clog2(nb) : 0);
  endfunction

  // index width for a lane counter, at least one bit
  function automatic int idx_width(input int nb);
    return (nb > 1) ? $clog2(nb) : 1;
  endfunction
endpackage

// File: rtl/sad_absdiff.sv
module sad_absdiff
  import sad_pkg::*;
(
  input  logic [LANE_W-1:0] lhs,
  input  logic [LANE_W-1:0] rhs,
  output logic [LANE_W-1:0] dif
);
  always_comb begin
    if (lhs >= rhs) dif = lhs - rhs;
    else            dif = rhs - lhs;
  end
endmodule

// File: rtl/sad_tree.sv
module sad_tree
  import sad_pkg::*;
#(
  parameter int NB    = 8,
  parameter int SUM_W = 11
) (
  input  logic [NB*LANE_W-1:0] opa,
  input  logic [NB*LANE_W-1:0] opb,
  output logic [SUM_W-1:0]     sum
);
  localparam int NP = 1 << $clog2(NB);

  // heap-ordered tree: node k has children 2k+1 and 2k+2
  logic [SUM_W-1:0] node [0:2*NP-2];

  for (genvar g = 0; g < NP; g++) begin : g_leaf
    if (g < NB) begin : g_live
      logic [LANE_W-1:0] d;
      sad_absdiff u_ad (
        .lhs(opa[g*LANE_W +: LANE_W]),
        .rhs(opb[g*LANE_W +: LANE_W]),
        .dif(d)
      );
      assign node[NP-1+g] = SUM_W'(d);
    end else begin : g_pad
      assign node[NP-1+g] = '0;
    end
  end

  for (genvar k = 0; k < NP-1; k++) begin : g_add
    assign node[k] = node[2*k+1] + node[2*k+2];
  end

  assign sum = node[0];
endmodule

// File: rtl/sad_par_engine.sv
module sad_par_engine
  import sad_pkg::*;
#(
  parameter int NB = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_acc,
  input  logic [NB*8-1:0]    src_a,
  input  logic [NB*8-1:0]    src_b,
  input  logic [NB*8-1:0]    dst_old,
  output logic               busy,
  output logic               res_valid,
  output logic [NB*8-1:0]    res_data
);
  localparam int XLEN  = NB * LANE_W;
  localparam int SUM_W = sum_width(NB);

  logic [SUM_W-1:0] lane_sum;
  logic [XLEN-1:0]  base;
  logic             vld_q;
  logic [XLEN-1:0]  res_q;

  sad_tree #(.NB(NB), .SUM_W(SUM_W)) u_tree (
    .opa(src_a),
    .opb(src_b),
    .sum(lane_sum)
  );

  assign base = req_acc ? dst_old : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= req_valid;
      if (req_valid) res_q <= base + XLEN'(lane_sum);
    end
  end

  assign busy      = 1'b0;
  assign res_valid = vld_q;
  assign res_data  = res_q;
endmodule

// File: rtl/sad_ser_engine.sv
module sad_ser_engine
  import sad_pkg::*;
#(
  parameter int NB = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_acc,
  input  logic [NB*8-1:0]    src_a,
  input  logic [NB*8-1:0]    src_b,
  input  logic [NB*8-1:0]    dst_old,
  output logic               busy,
  output logic               res_valid,
  output logic [NB*8-1:0]    res_data
);
  localparam int XLEN  = NB * LANE_W;
  localparam int IDX_W = idx_width(NB);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NB-1);

  logic [XLEN-1:0]   a_q, b_q, acc_q, res_q;
  logic [IDX_W-1:0]  idx_q;
  logic              busy_q, vld_q;
  logic [LANE_W-1:0] dif;
  logic [XLEN-1:0]   next_acc;

  // the low lane of each shifting operand is the pair in work
  sad_absdiff u_ad (
    .lhs(a_q[LANE_W-1:0]),
    .rhs(b_q[LANE_W-1:0]),
    .dif(dif)
  );

  assign next_acc = acc_q + XLEN'(dif);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      acc_q  <= '0;
      res_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (busy_q) begin
        acc_q <= next_acc;
        a_q   <= a_q >> LANE_W;
        b_q   <= b_q >> LANE_W;
        idx_q <= idx_q + 1'b1;
        if (idx_q == LAST) begin
          busy_q <= 1'b0;
          vld_q  <= 1'b1;
          res_q  <= next_acc;
        end
      end else if (req_valid) begin
        a_q    <= src_a;
        b_q    <= src_b;
        acc_q  <= req_acc ? dst_old : '0;
        idx_q  <= '0;
        busy_q <= 1'b1;
      end
    end
  end

  assign busy      = busy_q;
  assign res_valid = vld_q;
  assign res_data  = res_q;
endmodule

// File: rtl/sad_accum_unit.sv
module sad_accum_unit
  import sad_pkg::*;
#(
  parameter int XLEN_BYTES = 8,
  parameter bit SERIAL     = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic                       req_acc,
  input  logic [XLEN_BYTES*8-1:0]    src_a,
  input  logic [XLEN_BYTES*8-1:0]    src_b,
  input  logic [XLEN_BYTES*8-1:0]    dst_old,
  output logic                       busy,
  output logic                       res_valid,
  output logic [XLEN_BYTES*8-1:0]    res_data
);
  if (SERIAL) begin : g_serial
    sad_ser_engine #(.NB(XLEN_BYTES)) u_eng (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_acc(req_acc),
      .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
      .busy(busy), .res_valid(res_valid), .res_data(res_data)
    );
  end else begin : g_tree
    sad_par_engine #(.NB(XLEN_BYTES)) u_eng (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_acc(req_acc),
      .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
      .busy(busy), .res_valid(res_valid), .res_data(res_data)
    );
  end
endmodule

// File: rtl/sad_accum_checker.sv
module sad_accum_checker
  import sad_pkg::*;
#(
  parameter int XLEN_BYTES = 8,
  parameter bit SERIAL     = 1'b1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic                    req_acc,
  input logic                    busy,
  input logic                    res_valid,
  input logic [XLEN_BYTES*8-1:0] res_data
);
  localparam int XLEN   = XLEN_BYTES * LANE_W;
  localparam int MAXSUM = 255 * XLEN_BYTES;
  localparam int RUN_W  = $clog2(XLEN_BYTES + 2);

  logic             armed;
  logic             plain_q;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      plain_q <= 1'b0;
      run_q   <= '0;
    end else begin
      armed <= 1'b1;
      if (req_valid && !busy) plain_q <= !req_acc;
      if (busy) run_q <= run_q + 1'b1;
      else      run_q <= '0;
    end
  end

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !res_valid) |-> $stable(res_data));

  // R2
  plain_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && plain_q) |-> (res_data <= XLEN'(MAXSUM)));

  // R5
  strobe_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !busy);

  // R5
  busy_run_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_q < RUN_W'(XLEN_BYTES)));

  if (SERIAL) begin : g_ser_chk
    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      res_valid |=> !res_valid);
    // R6
    busy_take_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !busy && !res_valid) |=> busy);
  end else begin : g_par_chk
    // R4
    tree_latency_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> res_valid);
    // R4
    tree_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !busy);
  end
endmodule

bind sad_accum_unit sad_accum_checker #(
  .XLEN_BYTES(XLEN_BYTES),
  .SERIAL(SERIAL)
) u_chk (
  .clk(clk), .rst(rst),
  .req_valid(req_valid), .req_acc(req_acc),
  .busy(busy), .res_valid(res_valid), .res_data(res_data)
);

// File: tb/sad_accum_unit_test.sv
module sad_accum_unit_test;
  localparam int NBY = 8;
  localparam int XL  = NBY * 8;
  localparam int NV  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          u_req = 1'b0, t_req = 1'b0, acc = 1'b0;
  logic [XL-1:0] a = '0, b = '0, d = '0;
  logic          u_busy, u_vld, t_busy, t_vld;
  logic [XL-1:0] u_res, t_res;

  int checks = 0;
  int fails  = 0;

  sad_accum_unit #(.XLEN_BYTES(NBY), .SERIAL(1'b1)) uut (
    .clk(clk), .rst(rst), .req_valid(u_req), .req_acc(acc),
    .src_a(a), .src_b(b), .dst_old(d),
    .busy(u_busy), .res_valid(u_vld), .res_data(u_res));

  sad_accum_unit #(.XLEN_BYTES(NBY), .SERIAL(1'b0)) uut_tree (
    .clk(clk), .rst(rst), .req_valid(t_req), .req_acc(acc),
    .src_a(a), .src_b(b), .dst_old(d),
    .busy(t_busy), .res_valid(t_vld), .res_data(t_res));

  // stimulus and expected results
  localparam logic [XL-1:0] VA [NV] = '{
    64'h0, 64'h00000000000000FF, 64'h0, 64'h0102030405060708,
    64'h0102030405060708, 64'h10, 64'h80, 64'h8000000000000000};
  localparam logic [XL-1:0] VB [NV] = '{
    64'h0, 64'h0, 64'hFFFFFFFFFFFFFFFF, 64'h0807060504030201,
    64'h0807060504030201, 64'h0, 64'h7F, 64'h7F00000000000000};
  localparam logic [XL-1:0] VD [NV] = '{
    64'h55, 64'h0, 64'h0, 64'h0,
    64'h100, 64'hFFFFFFFFFFFFFFFF, 64'h1234, 64'h0};
  localparam bit VACC [NV] = '{0, 0, 0, 0, 1, 1, 0, 0};
  localparam logic [XL-1:0] VE [NV] = '{
    64'h0, 64'hFF, 64'h7F8, 64'h20, 64'h120, 64'hF, 64'h1, 64'h1};
  localparam string VTAG [NV] = '{
    "R9 zero", "R2 one lane", "R1 all 255", "R2 mixed",
    "R3 acc", "R3 wrap", "R9 dst ignored", "R1 top lane"};

  task automatic chk(input string tag, input logic [XL-1:0] act, input logic [XL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [XL-1:0] ia, input logic [XL-1:0] ib,
                       input logic [XL-1:0] id, input bit iacc, input bit to_tree);
    a = ia; b = ib; d = id; acc = iacc;
    u_req = 1'b1; t_req = to_tree;
    @(negedge clk);
    u_req = 1'b0; t_req = 1'b0;
  endtask

  // starts at the first negedge after acceptance (lat = 1)
  task automatic collect(output int lat, output int busy_n, output bit tree_pulse);
    lat = 1; busy_n = 0; tree_pulse = 1'b0;
    forever begin
      if (lat == 1) tree_pulse = t_vld;
      if (u_busy) busy_n++;
      if (u_vld || lat >= 40) break;
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int lat, busy_n, extra;
    bit tp;
    logic [XL-1:0] held;

    repeat (5) @(negedge clk);
    // R8 reset state on both engines
    chk("R8 u_vld",  XL'(u_vld),  '0);
    chk("R8 u_busy", XL'(u_busy), '0);
    chk("R8 u_res",  u_res,       '0);
    chk("R8 t_vld",  XL'(t_vld),  '0);
    chk("R8 t_res",  t_res,       '0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(VA[i], VB[i], VD[i], VACC[i], 1'b1);
      collect(lat, busy_n, tp);
      chk(VTAG[i], u_res, VE[i]);
      chk({"R7 ", VTAG[i]}, t_res, VE[i]);
      chk("R4 tree strobe", XL'(tp), XL'(1));
      chk("R5 latency", XL'(lat), XL'(NBY + 1));
      chk("R5 busy cycles", XL'(busy_n), XL'(NBY));
      held = u_res;
      @(negedge clk);
      chk("R10 hold", u_res, held);
      chk("R5 pulse", XL'(u_vld), '0);
    end

    // R6: request while busy is dropped
    issue(64'hFF, 64'h0, 64'h0, 1'b0, 1'b0);
    a = '1; b = '0; d = 64'h5; acc = 1'b1; u_req = 1'b1;
    @(negedge clk);
    u_req = 1'b0;
    collect(lat, busy_n, tp);
    chk("R6 result", u_res, 64'hFF);
    extra = 0;
    for (int k = 0; k < NBY + 3; k++) begin
      @(negedge clk);
      if (u_vld) extra++;
    end
    chk("R6 no extra strobe", XL'(extra), '0);

    // result strobe and next acceptance share a cycle
    issue(64'h0102030405060708, 64'h0807060504030201, 64'h0, 1'b0, 1'b1);
    collect(lat, busy_n, tp);
    chk("R2 first of pair", u_res, 64'h20);
    issue(64'h0, 64'hFFFFFFFFFFFFFFFF, 64'h1, 1'b1, 1'b1);
    collect(lat, busy_n, tp);
    chk("R3 second of pair", u_res, 64'h7F9);
    chk("R5 second latency", XL'(lat), XL'(NBY + 1));
    chk("R7 second of pair", t_res, 64'h7F9);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule